// File: doc/BRIEF.md
# Block Protection State Manager

This block holds the write-protection state of a set of memory blocks behind a flash-style command interface. Each block carries two flags: a lock flag that stops program and erase, and a lock-down flag that, while the write-protect pin is low, freezes the block's protection so that no command can change it. Software changes the flags with two-write command sequences: a setup write, then a confirm write whose opcode selects the action and whose address selects the block.

The block drives one registered program/erase permit bit per memory block, for use by the program and erase controller. It also answers a status query: a block index goes in, and a registered 2-bit protection code comes out. Reset puts every block back into the locked state and clears every lock-down flag.

Top module: `blk_protect_mgr`

## Requirements
- R1: While reset is high and on the first cycle after it, every block reads code 2'b01 (locked, not locked-down), every permit bit is 0, and seq_err is 0.
- R2: A command is the setup opcode (default 8'h60) written on one cycle with wr_en high, then a confirm write on a later wr_en cycle. The block index is taken from wr_addr on the confirm write. A confirm opcode written without a setup write before it is ignored.
- R3: The permit bit of a block is 1 only if the block's lock flag is 0 and lock-down is not being enforced on it. Otherwise it is 0.
- R4: The Lock confirm (default 8'h01) sets a block's lock flag. The Unlock confirm (default 8'hD0) clears it.
- R5: The Lock-Down confirm (default 8'h2F) sets both flags of the target block, whether that block was locked or unlocked before.
- R6: While wp is 0, a block whose lock-down flag is set keeps both flags through Lock, Unlock and Lock-Down commands, and its permit bit is 0.
- R7: While wp is 1, the lock-down flag has no effect. Unlock clears the lock flag of a locked-down block, and the permit bit then follows the lock flag alone.
- R8: Only reset clears a lock-down flag. Unlock never clears it.
- R9: q_code for the block at q_addr is registered: bit 0 is the lock flag and bit 1 is the lock-down flag.
- R10: A confirm write with any other opcode changes no flag, ends the command, and drives seq_err high for exactly the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_data | input | OPW | Opcode of the write |
| wr_addr | input | AW | Block index carried by the write |
| wp | input | 1 | Write-protect; lock-down is enforced while 0 |
| q_addr | input | AW | Block index for the status query |
| q_code | output | 2 | Registered protection code of the queried block |
| permit | output | NBLK | Registered program/erase permit, one bit per block |
| seq_err | output | 1 | One-cycle pulse after an unknown confirm opcode |

## Verification
The flags change on the clock edge that samples the confirm write. seq_err is valid from that same edge, so the bench reads it at the falling edge right after the confirm write. permit and q_code add one register stage, so their new values appear one edge later. The bench changes q_addr at the falling edge after the confirm write and reads q_code and the permit bit at the following falling edge. At that point both outputs reflect the command and the wp level that applied to it.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef enum logic [1:0] {
    CMD_LOCK   = 2'd0,
    CMD_UNLOCK = 2'd1,
    CMD_LDOWN  = 2'd2
  } cmd_e;
endpackage

// File: rtl/bpm_seq.sv
module bpm_seq
  import bpm_pkg::*;
#(
  parameter int                OPW       = 8,
  parameter int                AW        = 4,
  parameter logic [OPW-1:0]    OP_SETUP  = 8'h60,
  parameter logic [OPW-1:0]    OP_LOCK   = 8'h01,
  parameter logic [OPW-1:0]    OP_UNLOCK = 8'hD0,
  parameter logic [OPW-1:0]    OP_LDOWN  = 8'h2F
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [OPW-1:0] wr_data,
  input  logic [AW-1:0]  wr_addr,
  output logic           cmd_vld,
  output cmd_e           cmd_kind,
  output logic [AW-1:0]  cmd_addr,
  output logic           seq_err
);
  logic armed;
  logic known;

  always_comb begin
    known    = 1'b1;
    cmd_kind = CMD_LOCK;
    if (wr_data == OP_LOCK)        cmd_kind = CMD_LOCK;
    else if (wr_data == OP_UNLOCK) cmd_kind = CMD_UNLOCK;
    else if (wr_data == OP_LDOWN)  cmd_kind = CMD_LDOWN;
    else                           known    = 1'b0;
    cmd_vld  = armed && wr_en && known;
    cmd_addr = wr_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      seq_err <= armed && wr_en && !known;
      if (wr_en) armed <= armed ? 1'b0 : (wr_data == OP_SETUP);
    end
  end
endmodule

// File: rtl/bpm_bits.sv
module bpm_bits
  import bpm_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wp,
  input  logic            cmd_vld,
  input  cmd_e            cmd_kind,
  input  logic [AW-1:0]   cmd_addr,
  output logic [NBLK-1:0] lk_vec,
  output logic [NBLK-1:0] ldn_vec,
  output logic [NBLK-1:0] permit
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic hit;
    logic frozen;
    assign hit    = cmd_vld && (cmd_addr == AW'(i));
    assign frozen = ldn_vec[i] && !wp;

    always_ff @(posedge clk) begin
      if (rst) begin
        lk_vec[i]  <= 1'b1;
        ldn_vec[i] <= 1'b0;
        permit[i]  <= 1'b0;
      end else begin
        permit[i] <= !lk_vec[i] && !frozen;
        if (hit && !frozen) begin
          case (cmd_kind)
            CMD_LOCK:   lk_vec[i] <= 1'b1;
            CMD_UNLOCK: lk_vec[i] <= 1'b0;
            CMD_LDOWN: begin
              lk_vec[i]  <= 1'b1;
              ldn_vec[i] <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/bpm_query.sv
module bpm_query #(
  parameter int NBLK = 16,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   q_addr,
  input  logic [NBLK-1:0] lk_vec,
  input  logic [NBLK-1:0] ldn_vec,
  output logic [1:0]      q_code
);
  always_ff @(posedge clk) begin
    if (rst)                         q_code <= 2'b01;
    else if (int'(q_addr) < NBLK)    q_code <= {ldn_vec[q_addr], lk_vec[q_addr]};
    else                             q_code <= 2'b00;
  end
endmodule

// File: rtl/blk_protect_mgr.sv
module blk_protect_mgr
  import bpm_pkg::*;
#(
  parameter int             NBLK      = 16,
  parameter int             AW        = $clog2(NBLK),
  parameter int             OPW       = 8,
  parameter logic [OPW-1:0] OP_SETUP  = 8'h60,
  parameter logic [OPW-1:0] OP_LOCK   = 8'h01,
  parameter logic [OPW-1:0] OP_UNLOCK = 8'hD0,
  parameter logic [OPW-1:0] OP_LDOWN  = 8'h2F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [OPW-1:0]  wr_data,
  input  logic [AW-1:0]   wr_addr,
  input  logic            wp,
  input  logic [AW-1:0]   q_addr,
  output logic [1:0]      q_code,
  output logic [NBLK-1:0] permit,
  output logic            seq_err
);
  logic            cmd_vld;
  cmd_e            cmd_kind;
  logic [AW-1:0]   cmd_addr;
  logic [NBLK-1:0] lk_vec;
  logic [NBLK-1:0] ldn_vec;

  bpm_seq #(
    .OPW(OPW), .AW(AW), .OP_SETUP(OP_SETUP), .OP_LOCK(OP_LOCK),
    .OP_UNLOCK(OP_UNLOCK), .OP_LDOWN(OP_LDOWN)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_addr(wr_addr),
    .cmd_vld(cmd_vld), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .seq_err(seq_err)
  );

  bpm_bits #(.NBLK(NBLK), .AW(AW)) u_bits (
    .clk(clk), .rst(rst), .wp(wp), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .lk_vec(lk_vec), .ldn_vec(ldn_vec), .permit(permit)
  );

  bpm_query #(.NBLK(NBLK), .AW(AW)) u_query (
    .clk(clk), .rst(rst), .q_addr(q_addr), .lk_vec(lk_vec), .ldn_vec(ldn_vec),
    .q_code(q_code)
  );
endmodule

// File: rtl/bpm_chk.sv
module bpm_chk #(
  parameter int NBLK = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            wp,
  input logic [NBLK-1:0] permit,
  input logic            seq_err,
  input logic [NBLK-1:0] lk_vec,
  input logic [NBLK-1:0] ldn_vec
);
  AST_RST_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (permit == '0 && !seq_err)); // R1

  AST_NO_LOCKED_PERMIT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((permit & $past(lk_vec)) == '0)); // R3

  AST_WP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(ldn_vec & {NBLK{!wp}}) & (lk_vec ^ $past(lk_vec))) == '0)); // R6

  AST_LDN_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(ldn_vec) & ~ldn_vec) == '0)); // R8

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> ($past(wr_en) && !$past(rst))); // R10
endmodule

bind blk_protect_mgr bpm_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wp(wp), .permit(permit),
  .seq_err(seq_err), .lk_vec(lk_vec), .ldn_vec(ldn_vec)
);

// File: tb/sim_blk_protect_mgr.sv
module sim_blk_protect_mgr;
  localparam int NBLK = 16;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_data = '0;
  logic [AW-1:0]   wr_addr = '0;
  logic            wp = 1'b0;
  logic [AW-1:0]   q_addr = '0;
  logic [1:0]      q_code;
  logic [NBLK-1:0] permit;
  logic            seq_err;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  blk_protect_mgr #(.NBLK(NBLK)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_addr(wr_addr),
    .wp(wp), .q_addr(q_addr), .q_code(q_code), .permit(permit), .seq_err(seq_err)
  );

  // row: {op[1:0], block[3:0], wp, expected code[1:0], expected permit}
  // op 0 lock, 1 unlock, 2 lock-down, 3 unknown confirm (8'hFF)
  localparam logic [9:0] VEC [14] = '{
    {2'd1, 4'd3,  1'b0, 2'b00, 1'b1},  // R4 unlock, R3 permit
    {2'd0, 4'd3,  1'b0, 2'b01, 1'b0},  // R4 lock
    {2'd1, 4'd3,  1'b0, 2'b00, 1'b1},  // R4
    {2'd2, 4'd3,  1'b0, 2'b11, 1'b0},  // R5 from unlocked
    {2'd1, 4'd3,  1'b0, 2'b11, 1'b0},  // R6 frozen
    {2'd1, 4'd3,  1'b1, 2'b10, 1'b1},  // R7 unlock with wp high, R8 kept
    {2'd0, 4'd3,  1'b1, 2'b11, 1'b0},  // R7
    {2'd1, 4'd5,  1'b1, 2'b00, 1'b1},  // R4
    {2'd2, 4'd5,  1'b1, 2'b11, 1'b0},  // R5
    {2'd1, 4'd5,  1'b1, 2'b10, 1'b1},  // R7 R8
    {2'd3, 4'd5,  1'b0, 2'b10, 1'b0},  // R10 no change, R6 permit off
    {2'd0, 4'd5,  1'b0, 2'b10, 1'b0},  // R6 lock ignored
    {2'd1, 4'd0,  1'b0, 2'b00, 1'b1},  // R4
    {2'd2, 4'd15, 1'b0, 2'b11, 1'b0}   // R5 from locked
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic query(input logic [AW-1:0] a, output logic [1:0] c);
    q_addr = a;
    @(negedge clk);
    c = q_code;
  endtask

  function automatic logic [7:0] op_code(input logic [1:0] op);
    case (op)
      2'd0:    return 8'h01;
      2'd1:    return 8'hD0;
      2'd2:    return 8'h2F;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state of every block
    for (int b = 0; b < NBLK; b++) begin
      query(AW'(b), c);
      chk(c == 2'b01, "R1 reset code", c, 1);
    end
    chk(permit == '0, "R1 reset permit", permit, 0);
    chk(!seq_err, "R1 reset seq_err", seq_err, 0);

    // table walk
    for (int i = 0; i < 14; i++) begin
      wp = VEC[i][3];
      bus_wr(8'h60, VEC[i][7:4]);
      bus_wr(op_code(VEC[i][9:8]), VEC[i][7:4]);
      chk(seq_err == (VEC[i][9:8] == 2'd3), "R10 seq_err pulse", seq_err, (VEC[i][9:8] == 2'd3));
      query(VEC[i][7:4], c);
      chk(c == VEC[i][2:1], "R9 table code", c, VEC[i][2:1]);
      chk(permit[VEC[i][7:4]] == VEC[i][0], "R3 table permit", permit[VEC[i][7:4]], VEC[i][0]);
    end

    // R10 pulse lasts one cycle
    wp = 1'b0;
    bus_wr(8'h60, 4'd7);
    bus_wr(8'h55, 4'd7);
    chk(seq_err, "R10 pulse high", seq_err, 1);
    @(negedge clk);
    chk(!seq_err, "R10 pulse one cycle", seq_err, 0);

    // R2 confirm without setup is ignored (block 0 is unlocked)
    bus_wr(8'h01, 4'd0);
    chk(!seq_err, "R2 stray confirm no error", seq_err, 0);
    query(4'd0, c);
    chk(c == 2'b00, "R2 stray confirm ignored", c, 0);

    // R2 block index from the confirm write
    bus_wr(8'h60, 4'd9);
    bus_wr(8'hD0, 4'd10);
    query(4'd10, c);
    chk(c == 2'b00, "R2 confirm address used", c, 0);
    query(4'd9, c);
    chk(c == 2'b01, "R2 setup address unused", c, 1);

    // R8 unlock keeps lock-down with wp high
    wp = 1'b1;
    bus_wr(8'h60, 4'd15);
    bus_wr(8'hD0, 4'd15);
    query(4'd15, c);
    chk(c == 2'b10, "R8 lock-down kept", c, 2);
    chk(permit[15], "R7 permit with wp high", permit[15], 1);
    // R6 dropping wp re-enforces lock-down
    wp = 1'b0;
    repeat (2) @(negedge clk);
    chk(!permit[15], "R6 permit off when wp low", permit[15], 0);

    // R1 reset re-locks everything and clears lock-down
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(permit == '0, "R1 permit after reset", permit, 0);
    for (int b = 0; b < NBLK; b++) begin
      query(AW'(b), c);
      chk(c == 2'b01, "R1 R8 code after reset", c, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule